// File: doc/BRIEF.md
# Dual-Class Barrier-Aware Write Scheduler

This block sits in front of the banks of a multi-bank non-volatile memory and decides which pending write goes to which bank next. Every write that enters is tagged as either a scratch (working-memory) write or a durable (persistent-store) write. The tag comes from a 64-entry, one-bit-per-frame class map that is loaded through its own update port. Accepted writes wait in an 8-entry age-ordered queue. Each cycle, at most one of them is sent to a bank that has no write in flight, so writes to different banks overlap in time.

Ordering barriers arrive on a separate request input. They restrict durable writes only. A durable write that entered after a barrier stays in the queue until every durable write that entered before that barrier has left its bank. Scratch writes pass barriers freely. While any barrier is outstanding, a ready durable write wins over a ready scratch write. With no barrier outstanding, the oldest ready write wins whatever its class.

A bank stays busy for a fixed time after an issue: 4 cycles for a scratch write and 8 cycles for a durable write.

Top module: `dws_write_sched`

## Requirements
- R1: An accepted write is durable (`iss_persist`=1) when the class-map bit for its `wr_frame` is 1, and scratch when that bit is 0. After reset every map bit is 0.
- R2: A map update written in a cycle classifies writes accepted from the next cycle on. A write accepted in the same cycle as the update uses the old bit.
- R3: After an issue, `bank_busy` for that bank is 1 for exactly 4 cycles for a scratch write and exactly 8 cycles for a durable write, starting the cycle after the issue.
- R4: A write is never issued to a bank whose `bank_busy` bit is 1. Writes to different banks may be in flight together. A second write to the same bank issues no earlier than the cycle after that bank goes idle.
- R5: A scratch write issues regardless of any outstanding barrier.
- R6: Assume an earlier durable write issued in cycle i, and that no other durable write entered before the barrier. A durable write queued after that barrier issues no earlier than cycle i+10: the bank is busy through cycle i+8, is idle at i+9, and the barrier retires at the end of i+9. `bar_pending` is 1 from the cycle after a barrier is taken until it retires.
- R7: While `bar_pending` is 1, an eligible durable write is chosen over an eligible scratch write, even an older one.
- R8: While `bar_pending` is 0, the oldest eligible write is chosen, whatever its class.
- R9: `wr_ready` is 0 whenever 8 writes are queued. A write accepted in the same cycle as a barrier is ordered before that barrier.
- R10: After reset, `wr_ready`=1, `bar_ready`=1, `iss_valid`=0, `bank_busy`=0 and `bar_pending`=0.
- R11: A write accepted at a clock edge, targeting an idle bank with nothing older eligible, appears on `iss_*` in the cycle that edge starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write offered |
| wr_ready | output | 1 | Queue can take a write |
| wr_frame | input | 6 | Frame number of the write |
| wr_bank | input | 2 | Target bank of the write |
| bar_valid | input | 1 | Barrier request |
| bar_ready | output | 1 | A barrier can be taken (fewer than 7 outstanding) |
| map_we | input | 1 | Class-map update strobe |
| map_frame | input | 6 | Frame whose class bit is written |
| map_persist | input | 1 | New class bit (1 = durable) |
| iss_valid | output | 1 | A write is issued this cycle |
| iss_frame | output | 6 | Frame of the issued write |
| iss_bank | output | 2 | Bank of the issued write |
| iss_persist | output | 1 | Class of the issued write |
| bank_busy | output | 4 | One bit per bank: a write is in flight |
| bar_pending | output | 1 | At least one barrier not yet retired |

## Verification
The checker assumes three things. A barrier is offered only while `bar_ready` is 1. `iss_bank` is meaningful only while `iss_valid` is 1. Inputs are driven with settled values between clock edges, never X after reset. The stimulus meets all three. It drives every input on the falling edge and returns each strobe to 0 right after the edge that consumes it. It issues no more than one barrier at a time, far below the limit of 7. It gives each write in a scenario a distinct frame and bank pair, so every issue can be traced back to the write that caused it.

// File: rtl/dws_pkg.sv
package dws_pkg;
    localparam int NBANK   = 4;
    localparam int BANK_W  = $clog2(NBANK);
    localparam int FRAMES  = 64;
    localparam int FRAME_W = $clog2(FRAMES);
    localparam int QDEPTH  = 8;
    localparam int QIDX_W  = $clog2(QDEPTH);
    localparam int QCNT_W  = $clog2(QDEPTH + 1);
    localparam int EPOCH_W = 3;
    localparam int WM_BUSY = 4;
    localparam int PS_BUSY = 8;
    localparam int BUSY_W  = $clog2(PS_BUSY + 1);

    typedef struct packed {
        logic               valid;
        logic               persist;
        logic [EPOCH_W-1:0] epoch;
        logic [FRAME_W-1:0] frame;
        logic [BANK_W-1:0]  bank;
    } wq_entry_t;

    function automatic logic [BUSY_W-1:0] busy_len(input logic persist);
        return persist ? BUSY_W'(PS_BUSY) : BUSY_W'(WM_BUSY);
    endfunction
endpackage

// File: rtl/dws_class_map.sv
module dws_class_map
    import dws_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               upd_en,
    input  logic [FRAME_W-1:0] upd_frame,
    input  logic               upd_persist,
    input  logic [FRAME_W-1:0] look_frame,
    output logic               look_persist
);
    logic [FRAMES-1:0] map_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            map_q <= '0;
        end else if (upd_en) begin
            map_q[upd_frame] <= upd_persist;
        end
    end

    // Registered read path: an update is seen only from the next cycle.
    assign look_persist = map_q[look_frame];
endmodule

// File: rtl/dws_bank_timer.sv
module dws_bank_timer
    import dws_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               start_persist,
    input  logic [EPOCH_W-1:0] start_epoch,
    output logic               busy,
    output logic               held_persist,
    output logic [EPOCH_W-1:0] held_epoch
);
    logic [BUSY_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q       <= '0;
            held_persist <= 1'b0;
            held_epoch   <= '0;
        end else if (start) begin
            left_q       <= busy_len(start_persist);
            held_persist <= start_persist;
            held_epoch   <= start_epoch;
        end else if (left_q != '0) begin
            left_q <= left_q - BUSY_W'(1);
        end
    end

    assign busy = (left_q != '0);
endmodule

// File: rtl/dws_pick.sv
module dws_pick
    import dws_pkg::*;
(
    input  logic [QDEPTH-1:0] elig,
    input  logic [QDEPTH-1:0] pers,
    input  logic              favor_persist,
    output logic              pick_valid,
    output logic [QIDX_W-1:0] pick_idx
);
    logic [QDEPTH-1:0] cand;

    always_comb begin
        cand = elig;
        if (favor_persist && |(elig & pers)) begin
            cand = elig & pers;
        end
        pick_valid = |cand;
        pick_idx   = '0;
        // Slot 0 is the oldest entry, so the lowest set index wins.
        for (int i = QDEPTH - 1; i >= 0; i--) begin
            if (cand[i]) begin
                pick_idx = QIDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/dws_write_sched.sv
module dws_write_sched
    import dws_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_valid,
    output logic               wr_ready,
    input  logic [FRAME_W-1:0] wr_frame,
    input  logic [BANK_W-1:0]  wr_bank,
    input  logic               bar_valid,
    output logic               bar_ready,
    input  logic               map_we,
    input  logic [FRAME_W-1:0] map_frame,
    input  logic               map_persist,
    output logic               iss_valid,
    output logic [FRAME_W-1:0] iss_frame,
    output logic [BANK_W-1:0]  iss_bank,
    output logic               iss_persist,
    output logic [NBANK-1:0]   bank_busy,
    output logic               bar_pending
);
    localparam logic [QCNT_W-1:0] QFULL = QCNT_W'(QDEPTH);

    wq_entry_t          q_q [QDEPTH];
    wq_entry_t          q_d [QDEPTH];
    logic [QCNT_W-1:0]  cnt_q, cnt_d, wpos;
    logic [EPOCH_W-1:0] cur_ep_q, ret_ep_q, pend_cnt;
    logic               in_persist, push, bar_take, retire, old_live;
    logic [QDEPTH-1:0]  elig, pers;
    logic               pick_valid;
    logic [QIDX_W-1:0]  pick_idx;
    wq_entry_t          sel;
    logic [NBANK-1:0]   bank_start, bank_hp;
    logic [EPOCH_W-1:0] bank_he [NBANK];

    dws_class_map u_map (
        .clk(clk), .rst(rst),
        .upd_en(map_we), .upd_frame(map_frame), .upd_persist(map_persist),
        .look_frame(wr_frame), .look_persist(in_persist)
    );

    assign wr_ready    = (cnt_q != QFULL);
    assign push        = wr_valid && wr_ready;
    assign pend_cnt    = cur_ep_q - ret_ep_q;
    assign bar_pending = (pend_cnt != '0);
    assign bar_ready   = (pend_cnt != '1);
    assign bar_take    = bar_valid && bar_ready;

    always_comb begin
        for (int i = 0; i < QDEPTH; i++) begin
            pers[i] = q_q[i].persist;
            elig[i] = q_q[i].valid && !bank_busy[q_q[i].bank]
                      && (!q_q[i].persist || q_q[i].epoch == ret_ep_q);
        end
    end

    dws_pick u_pick (
        .elig(elig), .pers(pers), .favor_persist(bar_pending),
        .pick_valid(pick_valid), .pick_idx(pick_idx)
    );

    assign sel         = q_q[pick_idx];
    assign iss_valid   = pick_valid;
    assign iss_frame   = sel.frame;
    assign iss_bank    = sel.bank;
    assign iss_persist = sel.persist;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign bank_start[b] = pick_valid && (sel.bank == BANK_W'(b));
        dws_bank_timer u_timer (
            .clk(clk), .rst(rst),
            .start(bank_start[b]), .start_persist(sel.persist),
            .start_epoch(sel.epoch),
            .busy(bank_busy[b]), .held_persist(bank_hp[b]),
            .held_epoch(bank_he[b])
        );
    end

    // The oldest barrier retires once no durable write of the retiring
    // epoch remains queued or in flight.
    always_comb begin
        old_live = 1'b0;
        for (int i = 0; i < QDEPTH; i++) begin
            if (q_q[i].valid && q_q[i].persist && q_q[i].epoch == ret_ep_q) begin
                old_live = 1'b1;
            end
        end
        for (int b = 0; b < NBANK; b++) begin
            if (bank_busy[b] && bank_hp[b] && bank_he[b] == ret_ep_q) begin
                old_live = 1'b1;
            end
        end
    end
    assign retire = bar_pending && !old_live;

    // Compacting queue: remove the picked slot, then append at the tail.
    assign wpos = cnt_q - QCNT_W'(pick_valid);
    always_comb begin
        q_d = q_q;
        for (int i = 0; i < QDEPTH - 1; i++) begin
            if (pick_valid && QIDX_W'(i) >= pick_idx) begin
                q_d[i] = q_q[i + 1];
            end
        end
        if (pick_valid) begin
            q_d[QDEPTH-1] = '0;
        end
        if (push) begin
            q_d[QIDX_W'(wpos)].valid   = 1'b1;
            q_d[QIDX_W'(wpos)].persist = in_persist;
            q_d[QIDX_W'(wpos)].epoch   = cur_ep_q;
            q_d[QIDX_W'(wpos)].frame   = wr_frame;
            q_d[QIDX_W'(wpos)].bank    = wr_bank;
        end
        cnt_d = cnt_q + QCNT_W'(push) - QCNT_W'(pick_valid);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < QDEPTH; i++) begin
                q_q[i] <= '0;
            end
            cnt_q    <= '0;
            cur_ep_q <= '0;
            ret_ep_q <= '0;
        end else begin
            q_q      <= q_d;
            cnt_q    <= cnt_d;
            cur_ep_q <= cur_ep_q + EPOCH_W'(bar_take);
            ret_ep_q <= ret_ep_q + EPOCH_W'(retire);
        end
    end
endmodule

// File: rtl/dws_write_sched_chk.sv
module dws_write_sched_chk
    import dws_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_ready,
    input logic              bar_valid,
    input logic              bar_ready,
    input logic              iss_valid,
    input logic [BANK_W-1:0] iss_bank,
    input logic [NBANK-1:0]  bank_busy,
    input logic              bar_pending,
    input logic [QCNT_W-1:0] cnt_q
);
    assert_bank_free_R4: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> !bank_busy[iss_bank]);

    assert_bank_taken_R3: assert property (@(posedge clk) disable iff (rst)
        iss_valid |=> bank_busy[$past(iss_bank)]);

    assert_full_stall_R9: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == QCNT_W'(QDEPTH)) |-> !wr_ready);

    assert_count_bound_R9: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= QCNT_W'(QDEPTH));

    assert_barrier_raise_R6: assert property (@(posedge clk) disable iff (rst)
        (bar_valid && bar_ready) |=> bar_pending);
endmodule

bind dws_write_sched dws_write_sched_chk u_chk (
    .clk(clk), .rst(rst), .wr_ready(wr_ready), .bar_valid(bar_valid),
    .bar_ready(bar_ready), .iss_valid(iss_valid), .iss_bank(iss_bank),
    .bank_busy(bank_busy), .bar_pending(bar_pending), .cnt_q(cnt_q)
);

// File: tb/dws_write_sched_test.sv
module dws_write_sched_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // {frame[8:3], bank[2:1], class bit[0]}
    localparam logic [8:0] VEC [NVEC] = '{
        {6'd3, 2'd0, 1'b0}, {6'd4, 2'd1, 1'b1}, {6'd5, 2'd2, 1'b0},
        {6'd6, 2'd3, 1'b1}, {6'd63, 2'd0, 1'b1}, {6'd0, 2'd2, 1'b0}
    };

    logic       clk = 1'b0, rst = 1'b1;
    logic       wr_valid = 1'b0, bar_valid = 1'b0, map_we = 1'b0, map_persist = 1'b0;
    logic [5:0] wr_frame = '0, map_frame = '0;
    logic [1:0] wr_bank = '0;
    logic       wr_ready, bar_ready, iss_valid, iss_persist, bar_pending;
    logic [5:0] iss_frame;
    logic [1:0] iss_bank;
    logic [3:0] bank_busy;

    int checks = 0, fails = 0, cyc = 0, nlog = 0;
    int log_frame [64], log_bank [64], log_pers [64], log_cyc [64];
    bit done = 1'b0;

    dws_write_sched uut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_frame(wr_frame), .wr_bank(wr_bank), .bar_valid(bar_valid),
        .bar_ready(bar_ready), .map_we(map_we), .map_frame(map_frame),
        .map_persist(map_persist), .iss_valid(iss_valid), .iss_frame(iss_frame),
        .iss_bank(iss_bank), .iss_persist(iss_persist), .bank_busy(bank_busy),
        .bar_pending(bar_pending)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) begin
            nlog = 0;
        end else if (iss_valid && nlog < 64) begin
            log_frame[nlog] = iss_frame;
            log_bank[nlog]  = iss_bank;
            log_pers[nlog]  = iss_persist;
            log_cyc[nlog]   = cyc;
            nlog++;
        end
        cyc++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int find_issue(input int f, input int b);
        for (int k = 0; k < nlog; k++) begin
            if (log_frame[k] == f && log_bank[k] == b) return k;
        end
        return -1;
    endfunction

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(posedge clk); @(posedge clk); #1 rst = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_map(input int f, input bit v);
        @(negedge clk); map_we = 1'b1; map_frame = 6'(f); map_persist = v;
        @(posedge clk); #1 map_we = 1'b0;
    endtask

    task automatic put(input int f, input int b, input bit bar);
        @(negedge clk); wr_valid = 1'b1; wr_frame = 6'(f); wr_bank = 2'(b); bar_valid = bar;
        @(posedge clk); #1 wr_valid = 1'b0; bar_valid = 1'b0;
    endtask

    task automatic run_order(input bit with_bar);
        int ip, iw;
        do_reset();
        set_map(12, 1'b1);
        put(10, 0, 1'b0);       // scratch write, occupies bank 0
        put(11, 0, 1'b0);       // older scratch write
        put(12, 0, with_bar);   // durable write, barrier behind it
        idle(40);
        ip = find_issue(12, 0);
        iw = find_issue(11, 0);
        if (with_bar) begin
            check(ip >= 0 && iw >= 0 && log_cyc[ip] < log_cyc[iw], "R7 durable first",
                  ip, iw + 1);
            check(ip >= 0 && iw >= 0 && log_cyc[iw] - log_cyc[ip] == 9, "R4 same-bank gap",
                  (ip >= 0 && iw >= 0) ? log_cyc[iw] - log_cyc[ip] : -1, 9);
        end else begin
            check(ip >= 0 && iw >= 0 && log_cyc[iw] < log_cyc[ip], "R8 oldest first",
                  iw, ip + 1);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int f, b, p, n, i1, i2, i3;
        do_reset();
        // R10 reset state
        check(wr_ready == 1'b1, "R10 wr_ready", wr_ready, 1);
        check(bar_ready == 1'b1, "R10 bar_ready", bar_ready, 1);
        check(iss_valid == 1'b0, "R10 iss_valid", iss_valid, 0);
        check(bank_busy == 4'b0, "R10 bank_busy", bank_busy, 0);
        check(bar_pending == 1'b0, "R10 bar_pending", bar_pending, 0);

        // Table walk: classification, issue latency, busy time.
        for (int v = 0; v < NVEC; v++) begin
            f = int'(VEC[v][8:3]); b = int'(VEC[v][2:1]); p = int'(VEC[v][0]);
            set_map(f, p[0]);
            put(f, b, 1'b0);
            check(iss_valid && iss_frame == 6'(f) && iss_bank == 2'(b), "R11 issue next cycle",
                  int'(iss_valid), 1);
            check(iss_persist == p[0], "R1 class", int'(iss_persist), p);
            n = 0;
            for (int k = 0; k < 20; k++) begin
                @(posedge clk); #1;
                if (bank_busy[b]) n++;
                else break;
            end
            check(n == (p != 0 ? 8 : 4), "R3 busy cycles", n, p != 0 ? 8 : 4);
        end

        // R2: update and write in the same cycle use the old bit.
        do_reset();
        @(negedge clk);
        map_we = 1'b1; map_frame = 6'd40; map_persist = 1'b1;
        wr_valid = 1'b1; wr_frame = 6'd40; wr_bank = 2'd0;
        @(posedge clk); #1 map_we = 1'b0; wr_valid = 1'b0;
        put(40, 1, 1'b0);
        idle(20);
        i1 = find_issue(40, 0); i2 = find_issue(40, 1);
        check(i1 >= 0 && log_pers[i1] == 0, "R2 same-cycle old bit", i1 >= 0 ? log_pers[i1] : -1, 0);
        check(i2 >= 0 && log_pers[i2] == 1, "R2 next-cycle new bit", i2 >= 0 ? log_pers[i2] : -1, 1);

        // R7 / R8: durable versus older scratch write on the same bank.
        run_order(1'b1);
        run_order(1'b0);

        // R5 / R6 / R9: barrier ordering.
        do_reset();
        set_map(30, 1'b1);
        set_map(31, 1'b1);
        put(30, 0, 1'b1);   // durable write accepted with the barrier: ordered before it
        put(31, 1, 1'b0);   // durable write behind the barrier
        put(32, 2, 1'b0);   // scratch write
        idle(2);
        check(bar_pending == 1'b1, "R6 barrier pending", bar_pending, 1);
        idle(30);
        check(bar_pending == 1'b0, "R6 barrier retired", bar_pending, 0);
        i1 = find_issue(30, 0); i2 = find_issue(31, 1); i3 = find_issue(32, 2);
        check(i3 >= 0 && i2 >= 0 && log_cyc[i3] < log_cyc[i2], "R5 scratch passes barrier",
              i3, i2 + 1);
        check(i1 >= 0 && i2 >= 0 && log_cyc[i2] - log_cyc[i1] == 10, "R6 wait for older",
              (i1 >= 0 && i2 >= 0) ? log_cyc[i2] - log_cyc[i1] : -1, 10);
        check(i1 >= 0 && i3 >= 0 && log_cyc[i3] - log_cyc[i1] == 2, "R9 write with barrier goes first",
              (i1 >= 0 && i3 >= 0) ? log_cyc[i3] - log_cyc[i1] : -1, 2);

        // R9: queue full.
        do_reset();
        for (int k = 0; k < 9; k++) set_map(k, 1'b1);
        for (int k = 0; k < 9; k++) put(k, 0, 1'b0);
        check(wr_ready == 1'b0, "R9 ready low when full", wr_ready, 0);
        idle(120);
        check(wr_ready == 1'b1, "R9 ready after drain", wr_ready, 1);
        check(nlog == 9, "R4 all writes issued once", nlog, 9);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule